// File: doc/BRIEF.md
# Programmable-width serial word assembler

This slice collects a serial bit stream into a parallel word. Bits are sampled on a rising system clock edge when the serial clock enable is high. They fill the word from bit 0 upward, so the first bit received is the least significant. A row of tap outputs forms a thermometer of how many bits the current word already holds. The word length is not a fixed counter limit. It is set by feeding one chosen tap back into the next-word input. When that input goes high and the downstream store is not full, the slice raises its word-write strobe for one cycle. At the next clock edge it clears its bit position, so the next serial bit starts a new word.

Wider words are built by cascading identical slices. The least significant slice has its start input tied high. Each later slice takes its start input from the chosen tap of the slice before it, so it begins filling only once its predecessor holds its share of the word. The chosen tap of the last slice drives the next-word input of every slice, and all slices commit together. While the store reports full, a completed word is held unchanged and any serial bits that arrive meanwhile are dropped.

Top module: `serial_word_slice`

## Requirements
- R1: On a clock edge with `sclk_en_i` high, `start_i` high, `next_word_i` low and fewer than WIDTH bits held, the slice stores `sdata_i` at the current bit position and advances one position. The first bit after a commit or reset lands on `word_o[0]`, the next on `word_o[1]`, and so on.
- R2: `tap_o[k]` is high exactly when at least k+1 bits of the current word have been stored. With WIDTH = 9, `tap_o[7]` marks an 8-bit word and `tap_o[8]` marks a 9-bit word.
- R3: `wr_o` is high in every cycle where `next_word_i` is high and `full_i` is low. At the following clock edge the bit position returns to zero, so all taps read low.
- R4: While `next_word_i` and `full_i` are both high, `wr_o` stays low and `word_o` and `tap_o` hold their values. When `full_i` falls, `wr_o` rises for one cycle with the held word, and the commit follows.
- R5: While `start_i` is low, serial bits are ignored and `word_o` and `tap_o` do not change.
- R6: Once WIDTH bits are held, further serial bits are ignored until a commit.
- R7: A serial bit presented in a cycle where `next_word_i` is high is discarded. It neither enters the word nor counts as the first bit of the next word.
- R8: A synchronous active-high `rst` clears the bit position and all word bits, so `tap_o` and `word_o` read zero after the edge.
- R9: Two slices cascaded, with the low slice's start tied high, the high slice's start driven by the low slice's `tap_o[7]`, and both next-word inputs driven by the high slice's `tap_o[7]`, assemble a 16-bit word. The low slice's `word_o[7:0]` holds bits 0 to 7 and the high slice's `word_o[7:0]` holds bits 8 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_en_i | input | 1 | Serial clock enable; one bit is offered per enabled edge |
| sdata_i | input | 1 | Serial data bit |
| start_i | input | 1 | Allows capture; tie high on the first slice, or take a tap of the previous slice |
| next_word_i | input | 1 | Word-complete input, wired from the chosen tap |
| full_i | input | 1 | Downstream store full; blocks the commit |
| tap_o | output | WIDTH | Thermometer of stored bit count; bit k is high after k+1 bits |
| word_o | output | WIDTH | Assembled parallel word |
| wr_o | output | 1 | Word-write strobe to the store |

## Verification
On every cycle the assertions check four things: a blocked commit keeps the word and taps frozen, a low start or an arriving word boundary leaves the word untouched, each accepted bit adds exactly one tap, and a commit empties the taps. Only the bench scenarios can show the actual bit values. These include least-significant-first placement, the 8-bit and 9-bit lengths chosen by tap wiring, the held word reappearing with a single strobe once full drops, and the 16-bit value split across a two-slice cascade.

// File: rtl/serial_word_slice.sv
module serial_word_slice #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_en_i,
  input  logic             sdata_i,
  input  logic             start_i,
  input  logic             next_word_i,
  input  logic             full_i,
  output logic [WIDTH-1:0] tap_o,
  output logic [WIDTH-1:0] word_o,
  output logic             wr_o
);
  localparam int PW = $clog2(WIDTH + 1);

  logic [PW-1:0] pos;
  logic          commit;
  logic          cap;

  assign commit = next_word_i & ~full_i;
  assign wr_o   = commit;
  assign cap    = sclk_en_i & start_i & ~next_word_i & (pos < PW'(WIDTH));

  always_ff @(posedge clk) begin
    if (rst)         pos <= '0;
    else if (commit) pos <= '0;
    else if (cap)    pos <= pos + PW'(1);
  end

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    localparam logic [PW-1:0] K = PW'(k);
    logic q;
    always_ff @(posedge clk) begin
      if (rst)                  q <= 1'b0;
      else if (cap && pos == K) q <= sdata_i;
    end
    assign word_o[k] = q;
    assign tap_o[k]  = (pos > K);
  end

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (tap_o == '0 && word_o == '0));

  p_commit_empties_r3: assert property (@(posedge clk) disable iff (rst)
    wr_o |=> (tap_o == '0));

  p_blocked_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (next_word_i && full_i) |=> ($stable(word_o) && $stable(tap_o)));

  p_no_start_r5: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !next_word_i) |=> ($stable(word_o) && $stable(tap_o)));

  p_full_word_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (tap_o[WIDTH-1] && !wr_o) |=> $stable(word_o));

  p_boundary_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (sclk_en_i && next_word_i) |=> $stable(word_o));

  p_one_step_r1: assert property (@(posedge clk) disable iff (rst)
    (sclk_en_i && start_i && !next_word_i && !tap_o[WIDTH-1])
      |=> ($countones(tap_o) == $past($countones(tap_o)) + 1));
endmodule

// File: tb/serial_word_slice_tb.sv
module serial_word_slice_tb;
  localparam int W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, sd = 1'b0, start = 1'b1, full = 1'b0;
  logic [1:0] nw_mode = 2'd1;
  logic nw;
  logic [W-1:0] tap, word;
  logic wr;

  logic cen = 1'b0, csd = 1'b0;
  logic [W-1:0] lo_tap, lo_word, hi_tap, hi_word;
  logic lo_wr, hi_wr, c_nw;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign nw = (nw_mode == 2'd0) ? tap[7] : (nw_mode == 2'd1) ? tap[8] : 1'b0;
  assign c_nw = hi_tap[7];

  serial_word_slice #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .sclk_en_i(en), .sdata_i(sd), .start_i(start),
    .next_word_i(nw), .full_i(full), .tap_o(tap), .word_o(word), .wr_o(wr));

  serial_word_slice #(.WIDTH(W)) u_casc_lo (
    .clk(clk), .rst(rst), .sclk_en_i(cen), .sdata_i(csd), .start_i(1'b1),
    .next_word_i(c_nw), .full_i(1'b0), .tap_o(lo_tap), .word_o(lo_word), .wr_o(lo_wr));

  serial_word_slice #(.WIDTH(W)) u_casc_hi (
    .clk(clk), .rst(rst), .sclk_en_i(cen), .sdata_i(csd), .start_i(lo_tap[7]),
    .next_word_i(c_nw), .full_i(1'b0), .tap_o(hi_tap), .word_o(hi_word), .wr_o(hi_wr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sd = b; en = 1'b1;
    @(negedge clk); en = 1'b0;
  endtask

  task automatic send_casc(input logic b);
    @(negedge clk); csd = b; cen = 1'b1;
    @(negedge clk); cen = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 taps after reset", 32'(tap), 32'h0);
    chk("R8 word after reset", 32'(word), 32'h0);
    chk("R8 strobe after reset", 32'(wr), 32'h0);
  endtask

  task automatic t_nine_bit;
    logic [8:0] v = 9'h1A5;
    @(negedge clk); nw_mode = 2'd1;
    for (int i = 0; i < 3; i++) send_bit(v[i]);
    chk("R2 taps after 3 bits", 32'(tap), 32'h007);
    for (int i = 3; i < 9; i++) send_bit(v[i]);
    chk("R1 nine-bit word lsb first", 32'(word), 32'h1A5);
    chk("R3 strobe at word end", 32'(wr), 32'h1);
    @(negedge clk);
    chk("R3 taps cleared after commit", 32'(tap), 32'h0);
    chk("R3 strobe single cycle", 32'(wr), 32'h0);
  endtask

  task automatic t_eight_bit;
    logic [7:0] v = 8'hC3;
    @(negedge clk); nw_mode = 2'd0;
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    chk("R2 eight-bit taps", 32'(tap), 32'h0FF);
    chk("R1 eight-bit word", 32'(word[7:0]), 32'hC3);
    chk("R3 eight-bit strobe", 32'(wr), 32'h1);
    @(negedge clk);
  endtask

  task automatic t_full_block;
    logic [8:0] v = 9'h0F0;
    @(negedge clk); nw_mode = 2'd1; full = 1'b1;
    for (int i = 0; i < 9; i++) send_bit(v[i]);
    chk("R4 no strobe while full", 32'(wr), 32'h0);
    chk("R4 taps held while full", 32'(tap), 32'h1FF);
    send_bit(1'b1);
    send_bit(1'b1);
    chk("R7 extra bits dropped, word", 32'(word), 32'h0F0);
    chk("R4 taps still held", 32'(tap), 32'h1FF);
    full = 1'b0;
    #1;
    chk("R4 strobe when full drops", 32'(wr), 32'h1);
    chk("R4 held word delivered", 32'(word), 32'h0F0);
    @(negedge clk);
    chk("R4 commit after release", 32'(tap), 32'h0);
    chk("R4 strobe one cycle", 32'(wr), 32'h0);
  endtask

  task automatic t_no_start;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    chk("R5 taps with start low", 32'(tap), 32'h0);
    chk("R5 word with start low", 32'(word), 32'h0F0);
    start = 1'b1;
  endtask

  task automatic t_overrun;
    logic [10:0] v = 11'h5C3;
    @(negedge clk); nw_mode = 2'd2;
    for (int i = 0; i < 11; i++) send_bit(v[i]);
    chk("R6 taps saturate", 32'(tap), 32'h1FF);
    chk("R6 extra bits ignored", 32'(word), 32'h1C3);
    chk("R6 no strobe without next-word", 32'(wr), 32'h0);
    nw_mode = 2'd1;
    #1;
    chk("R3 strobe on next-word", 32'(wr), 32'h1);
    @(negedge clk);
    chk("R3 taps cleared", 32'(tap), 32'h0);
  endtask

  task automatic t_boundary_bit;
    logic [8:0] v = 9'h0AA;
    @(negedge clk); nw_mode = 2'd1;
    for (int i = 0; i < 9; i++) send_bit(v[i]);
    chk("R3 strobe before boundary bit", 32'(wr), 32'h1);
    sd = 1'b1; en = 1'b1;
    @(negedge clk); en = 1'b0;
    chk("R7 boundary bit not counted", 32'(tap), 32'h0);
    chk("R7 boundary bit not stored", 32'(word), 32'h0AA);
  endtask

  task automatic t_cascade;
    logic [15:0] v = 16'hBEEF;
    for (int i = 0; i < 8; i++) send_casc(v[i]);
    chk("R9 low slice taps at 8", 32'(lo_tap), 32'h0FF);
    chk("R9 high slice idle at 8", 32'(hi_tap), 32'h0);
    for (int i = 8; i < 16; i++) send_casc(v[i]);
    chk("R9 both strobes", 32'({lo_wr, hi_wr}), 32'h3);
    chk("R9 cascaded word", 32'({hi_word[7:0], lo_word[7:0]}), 32'hBEEF);
    @(negedge clk);
    chk("R9 cascade cleared", 32'({hi_tap, lo_tap}), 32'h0);
  endtask

  initial begin
    #4_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_nine_bit();
    t_eight_bit();
    t_full_block();
    t_no_start();
    t_overrun();
    t_boundary_bit();
    t_cascade();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule